// File: doc/BRIEF.md
# Conditional Compare-and-Store Atomic Unit

This block executes one atomic word compare-and-store against a single-ported synchronous memory, as needed by a processor's multiprocessor-synchronization instruction. A start request supplies a base register value, an 8-bit unsigned word offset and the current contents of the destination register. The unit forms the byte address, reads the addressed word, and writes the captured destination value back to memory only if the word read equals a 32-bit comparand. The old memory word is always returned for the destination register, whether or not the store happened.

The comparand lives in a special register inside the unit, at special-register number 12. It has its own write and read ports so software can set and inspect it. While a sequence runs, the unit holds a bus lock so that no other master can slip in between the read and the write. A write to the comparand that arrives during a sequence is refused and the stall output is raised. Misaligned addresses are reported and produce no memory access. When the synchronization option is left out at build time, every request is flagged as illegal and touches nothing.

Top module: `cas_unit`

## Requirements
- R1: The access address on `mem_addr_o` equals `base_i + (offset_i << 2)` modulo 2^32. The same address is used for the read and for any write.
- R2: The comparand resets to 0. A write with `sr_we_i=1` and `sr_waddr_i=12` while the unit is idle loads `sr_wdata_i`, and the new value is visible at the next cycle. `sr_rdata_o` shows the comparand when `sr_raddr_i=12` and 0 for any other number.
- R3: While `busy_o=1`, `sr_stall_o` follows `sr_we_i` when the write targets number 12, and the comparand keeps its value.
- R4: The store data is `data_i` as captured on the accepting clock edge. When `done_o` pulses, `result_o` holds the word read from memory, whether or not the store happened.
- R5: The word is written (`mem_we_o=1`, `mem_wdata_o` = captured data) only if the word read equals the comparand, and `stored_o=1` reports this. Otherwise memory is unchanged and `stored_o=0`.
- R6: The sequence is: accept, read, compare, then write (on a match), then done. `done_o` is a one-cycle pulse. It comes 4 cycles after acceptance with a store and 3 cycles without one. `mem_lock_o` is high from the read cycle through the compare and write cycles.
- R7: If `base_i[1:0]` is not 0, the unit raises `align_err_o`, makes no memory request, and pulses `done_o` 1 cycle after acceptance.
- R8: With `SYNC_OPT=0`, every request raises `illegal_o`, makes no memory request, and pulses `done_o` 1 cycle after acceptance.
- R9: `start_i` is ignored while `busy_o=1`. No extra sequence or `done_o` follows.
- R10: After reset the unit is idle: `busy_o`, `done_o`, `mem_req_o`, `mem_lock_o` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request an operation (accepted when idle) |
| base_i | input | 32 | Base register value |
| offset_i | input | 8 | Unsigned word offset |
| data_i | input | 32 | Destination register value (store data) |
| sr_we_i | input | 1 | Special-register write strobe |
| sr_waddr_i | input | 8 | Special-register write number |
| sr_wdata_i | input | 32 | Special-register write data |
| sr_raddr_i | input | 8 | Special-register read number |
| sr_rdata_o | output | 32 | Special-register read data |
| sr_stall_o | output | 1 | Comparand write refused, unit busy |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read request |
| mem_lock_o | output | 1 | Bus lock held across the read-modify-write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Old memory word for the destination register |
| stored_o | output | 1 | Store was performed |
| align_err_o | output | 1 | Address was misaligned, access skipped |
| illegal_o | output | 1 | Synchronization option absent |

## Verification
The assertions check, on every cycle, that:
- a compare mismatch is never followed by a write;
- a write only comes straight after a compare;
- a misaligned request produces the error flag with no memory request;
- the comparand does not change while the unit is busy;
- a start during a sequence leaves the captured operands untouched.

Only the bench scenarios can show the data path end to end: the computed address, the old word returned, the memory contents after a store or a refused store, the latency of each path, and the illegal-option build. For this the bench keeps a shadow memory and sweeps base, offset and match outcome.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_CMP   = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } cas_state_e;
endpackage

// File: rtl/cas_cmp_reg.sv
module cas_cmp_reg #(
  parameter int DW     = 32,
  parameter int SR_AW  = 8,
  parameter int SR_NUM = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             we_i,
  input  logic [SR_AW-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [SR_AW-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o,
  output logic [DW-1:0]    cmp_o,
  output logic             stall_o
);
  localparam logic [SR_AW-1:0] SelNum = SR_AW'(SR_NUM);

  logic [DW-1:0] cmp_q;
  logic          hit_w;

  assign hit_w   = we_i && (waddr_i == SelNum);
  assign stall_o = hit_w && busy_i;
  assign cmp_o   = cmp_q;
  assign rdata_o = (raddr_i == SelNum) ? cmp_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cmp_q <= '0;
    else if (hit_w && !busy_i) cmp_q <= wdata_i;
  end

  // R3
  cmp_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cmp_q));
endmodule

// File: rtl/cas_addr_gen.sv
module cas_addr_gen #(
  parameter int AW    = 32,
  parameter int OFF_W = 8
) (
  input  logic [AW-1:0]    base_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [AW-1:0]    addr_o,
  output logic             misalign_o
);
  logic [AW-1:0] off_ext;
  assign off_ext    = AW'(offset_i) << 2;
  assign addr_o     = base_i + off_ext;
  assign misalign_o = |addr_o[1:0];
endmodule

// File: rtl/cas_seq.sv
module cas_seq
  import cas_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          legal_i,
  input  logic          misalign_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] cmp_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_lock_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  output logic          stored_o,
  output logic          align_err_o,
  output logic          illegal_o
);
  cas_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, old_q;
  logic          stored_q, align_q, ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      old_q    <= '0;
      stored_q <= 1'b0;
      align_q  <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          addr_q   <= addr_i;
          data_q   <= data_i;   // captured before the read overwrites the register
          old_q    <= '0;
          stored_q <= 1'b0;
          align_q  <= legal_i && misalign_i;
          ill_q    <= !legal_i;
          state_q  <= (!legal_i || misalign_i) ? S_DONE : S_READ;
        end
        S_READ: state_q <= S_CMP;
        S_CMP: begin
          old_q <= mem_rdata_i;
          if (mem_rdata_i == cmp_i) begin
            stored_q <= 1'b1;
            state_q  <= S_WRITE;
          end else begin
            state_q <= S_DONE;
          end
        end
        S_WRITE: state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == S_READ) || (state_q == S_WRITE);
  assign mem_we_o    = (state_q == S_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign mem_lock_o  = (state_q == S_READ) || (state_q == S_CMP) || (state_q == S_WRITE);
  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign result_o    = old_q;
  assign stored_o    = stored_q;
  assign align_err_o = align_q;
  assign illegal_o   = ill_q;

  // R5
  no_store_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMP && mem_rdata_i != cmp_i) |=> !mem_we_o);
  // R6
  wr_after_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($past(state_q) == S_CMP && $past(mem_lock_o)));
  // R7
  misalign_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && legal_i && misalign_i) |=> (!mem_req_o && align_err_o));
  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(addr_q) && $stable(data_q)));
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/cas_unit.sv
module cas_unit #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int OFF_W    = 8,
  parameter int SR_AW    = 8,
  parameter int SR_NUM   = 12,
  parameter bit SYNC_OPT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [DW-1:0]    data_i,
  input  logic             sr_we_i,
  input  logic [SR_AW-1:0] sr_waddr_i,
  input  logic [DW-1:0]    sr_wdata_i,
  input  logic [SR_AW-1:0] sr_raddr_i,
  output logic [DW-1:0]    sr_rdata_o,
  output logic             sr_stall_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             mem_lock_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    result_o,
  output logic             stored_o,
  output logic             align_err_o,
  output logic             illegal_o
);
  logic [AW-1:0] addr_w;
  logic          misalign_w, legal_w, busy_w;
  logic [DW-1:0] cmp_w;

  generate
    if (SYNC_OPT) begin : g_sync
      assign legal_w = 1'b1;
    end else begin : g_nosync
      assign legal_w = 1'b0;
    end
  endgenerate

  cas_addr_gen #(.AW(AW), .OFF_W(OFF_W)) u_addr (
    .base_i     (base_i),
    .offset_i   (offset_i),
    .addr_o     (addr_w),
    .misalign_o (misalign_w)
  );

  cas_cmp_reg #(.DW(DW), .SR_AW(SR_AW), .SR_NUM(SR_NUM)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy_w),
    .we_i    (sr_we_i),
    .waddr_i (sr_waddr_i),
    .wdata_i (sr_wdata_i),
    .raddr_i (sr_raddr_i),
    .rdata_o (sr_rdata_o),
    .cmp_o   (cmp_w),
    .stall_o (sr_stall_o)
  );

  cas_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .legal_i     (legal_w),
    .misalign_i  (misalign_w),
    .addr_i      (addr_w),
    .data_i      (data_i),
    .cmp_i       (cmp_w),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_lock_o  (mem_lock_o),
    .busy_o      (busy_w),
    .done_o      (done_o),
    .result_o    (result_o),
    .stored_o    (stored_o),
    .align_err_o (align_err_o),
    .illegal_o   (illegal_o)
  );

  assign busy_o = busy_w;

  // R6
  req_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_lock_o);
endmodule

// File: tb/tb_cas_unit.sv
module tb_cas_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, start_off = 1'b0;
  logic [31:0] base = '0, data = '0;
  logic [7:0]  offset = '0;
  logic        sr_we = 1'b0;
  logic [7:0]  sr_waddr = '0, sr_raddr = 8'd12;
  logic [31:0] sr_wdata = '0, sr_rdata;
  logic        sr_stall;
  logic        mem_req, mem_we, mem_lock, busy, done, stored, align_err, illegal;
  logic [31:0] mem_addr, mem_wdata, result;
  logic [31:0] mem_rdata = '0;

  logic [31:0] o_sr_rdata, o_mem_addr, o_mem_wdata, o_result;
  logic        o_sr_stall, o_mem_req, o_mem_we, o_mem_lock, o_busy, o_done;
  logic        o_stored, o_align, o_illegal;

  int checks = 0, failures = 0;
  int req_cnt = 0, off_req_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] mem [16];
  logic [31:0] exp_mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  cas_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .offset_i(offset),
    .data_i(data), .sr_we_i(sr_we), .sr_waddr_i(sr_waddr), .sr_wdata_i(sr_wdata),
    .sr_raddr_i(sr_raddr), .sr_rdata_o(sr_rdata), .sr_stall_o(sr_stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_lock_o(mem_lock),
    .busy_o(busy), .done_o(done), .result_o(result), .stored_o(stored),
    .align_err_o(align_err), .illegal_o(illegal)
  );

  cas_unit #(.SYNC_OPT(1'b0)) dut_off (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_off), .base_i(base), .offset_i(offset),
    .data_i(data), .sr_we_i(1'b0), .sr_waddr_i(8'd0), .sr_wdata_i(32'd0),
    .sr_raddr_i(8'd12), .sr_rdata_o(o_sr_rdata), .sr_stall_o(o_sr_stall),
    .mem_req_o(o_mem_req), .mem_we_o(o_mem_we), .mem_addr_o(o_mem_addr),
    .mem_wdata_o(o_mem_wdata), .mem_rdata_i(32'd0), .mem_lock_o(o_mem_lock),
    .busy_o(o_busy), .done_o(o_done), .result_o(o_result), .stored_o(o_stored),
    .align_err_o(o_align), .illegal_o(o_illegal)
  );

  // synchronous single-port memory model, word index from address bits 5:2
  always @(posedge clk) begin
    if (mem_req) begin
      req_cnt <= req_cnt + 1;
      last_addr <= mem_addr;
      if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[5:2]];
    end
    if (o_mem_req) off_req_cnt <= off_req_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sr_write(input logic [7:0] num, input logic [31:0] val);
    @(negedge clk);
    sr_we = 1'b1; sr_waddr = num; sr_wdata = val;
    @(negedge clk);
    sr_we = 1'b0;
  endtask

  // issue an op; n = negedges after the accepting edge until done_o seen
  task automatic run_op(input logic [31:0] b, input logic [7:0] o, input logic [31:0] d,
                        output int n);
    @(negedge clk);
    base = b; offset = o; data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0; base = 32'hFFFF_FFF0; data = 32'hDEAD_BEEF;
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, rc;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h1357_9BDF * (i + 1) ^ 32'h0F0F_0000;
      exp_mem[i] = mem[i];
    end
    #(CLK_PERIOD * 2 + 1);
    // R10 reset state
    chk("R10 busy", {31'd0, busy}, 0);
    chk("R10 outs", {25'd0, done, mem_req, mem_lock, stored, align_err, illegal, mem_we}, 0);
    chk("R2 reset cmp", sr_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 write/read ports
    sr_write(8'd12, 32'hCAFE_0012);
    chk("R2 readback", sr_rdata, 32'hCAFE_0012);
    sr_write(8'd13, 32'h1111_1111);
    chk("R2 other num write ignored", sr_rdata, 32'hCAFE_0012);
    sr_raddr = 8'd3; #1;
    chk("R2 other num reads 0", sr_rdata, 0);
    sr_raddr = 8'd12;

    // sweep: base, offset and match outcome
    for (int k = 0; k < 32; k++) begin
      logic [31:0] b, ba, d, cmpv;
      logic [7:0]  o;
      int idx;
      bit hit;
      b   = 32'(k % 16) * 4 + 32'h100;
      o   = 8'((k * 3) % 8);
      ba  = b + 32'(o) * 4;
      idx = int'(ba[5:2]);
      hit = (k % 2) == 0;
      d   = 32'hA500_0000 + 32'(k);
      cmpv = hit ? exp_mem[idx] : exp_mem[idx] ^ 32'h1;
      sr_write(8'd12, cmpv);
      rc = req_cnt;
      run_op(b, o, d, n);
      chk("R4 result old word", result, exp_mem[idx]);
      chk("R5 stored flag", {31'd0, stored}, {31'd0, hit});
      chk("R6 latency", n, hit ? 4 : 3);
      chk("R1 address", last_addr, ba);
      chk("R6 request count", req_cnt - rc, hit ? 2 : 1);
      if (hit) exp_mem[idx] = d;
      @(negedge clk);
      chk("R5 memory word", mem[idx], exp_mem[idx]);
      chk("R6 done single pulse", {31'd0, done}, 0);
    end

    // R1 largest offset, address wrap
    sr_write(8'd12, 32'h0);
    run_op(32'hFFFF_FF00, 8'hFF, 32'h5, n);
    chk("R1 max offset wrap", last_addr, 32'h0000_02FC);
    if (result == 32'h0) exp_mem[15] = 32'h5;
    @(negedge clk);
    chk("R5 wrap word", mem[15], exp_mem[15]);

    // R7 misaligned
    rc = req_cnt;
    run_op(32'h0000_0102, 8'h01, 32'h77, n);
    chk("R7 align flag", {31'd0, align_err}, 1);
    chk("R7 latency", n, 1);
    chk("R7 no access", req_cnt - rc, 0);

    // R3 stall and R9 ignored start during busy
    sr_write(8'd12, 32'h0BAD_0000);
    rc = req_cnt;
    @(negedge clk);
    base = 32'h100; offset = 8'd0; data = 32'h9; start = 1'b1;
    @(negedge clk);
    start = 1'b1; base = 32'h120;
    sr_we = 1'b1; sr_waddr = 8'd12; sr_wdata = 32'h1234_5678;
    #1;
    chk("R3 stall raised", {31'd0, sr_stall}, 1);
    @(negedge clk);
    start = 1'b0; sr_we = 1'b0;
    chk("R3 comparand kept", sr_rdata, 32'h0BAD_0000);
    while (!done) @(negedge clk);
    chk("R9 address of first op kept", last_addr, 32'h100);
    for (int w = 0; w < 6; w++) begin
      @(negedge clk);
      if (done || busy) chk("R9 no extra op", 1, 0);
    end
    chk("R9 one read only", req_cnt - rc, 1);

    // R8 option absent
    @(negedge clk);
    base = 32'h100; start_off = 1'b1;
    @(negedge clk);
    start_off = 1'b0;
    chk("R8 done after 1", {31'd0, o_done}, 1);
    chk("R8 illegal flag", {31'd0, o_illegal}, 1);
    @(negedge clk);
    chk("R8 no access", off_req_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule